// File: doc/BRIEF.md
# Ring-Keyed Set-Associative Translation Lookup

This block translates a virtual address into a physical address through a small table of translation entries arranged as several ways. Each way covers its own page size. An entry is selected in each way by the address bits just above that way's page offset. Every entry stores a virtual tag, a physical page, an address-space identifier and a 4-bit attribute code. Entries are loaded one at a time through a write port that names the target way. The slot inside the way is taken from the written virtual address.

Address-space identifiers are not compared with the requester directly. A 32-bit ring-identifier register holds four 8-bit identifiers, one for each privilege ring. An entry counts only if its identifier appears in that register, and the byte position where it appears gives the entry's ring. A lookup request carries the address, an instruction-or-data selector, an access type and the requester's ring. One cycle later the block returns either a physical address with its access rights and cache mode, or a fault cause.

Top module: `tlb_lookup`

## Requirements
- R1: A lookup accepted on a rising edge with `lk_valid` high produces `res_valid` high on the next rising edge. Without a request, `res_valid` is low. Reset clears `res_valid`.
- R2: An entry in way w hits when all of the following hold. Its stored tag equals the lookup address with that way's page-offset bits cleared. Its identifier is nonzero. Its identifier is found in the ring register. Way w's page offset is 12+2w bits, and its entry index is the next 2 address bits above the offset.
- R3: An entry's ring is the lowest byte index (byte 0 = bits 7:0) of the ring register equal to its identifier, and is reported on `res_ring`. An identifier that matches no byte makes the entry behave as absent.
- R4: When two or more ways hit, the cause is 2 for an instruction lookup and 6 for a data lookup.
- R5: When no way hits, the cause is 1 for an instruction lookup and 5 for a data lookup.
- R6: On a single hit whose ring is numerically below `lk_priv`, the cause is 3 for an instruction lookup and 7 for a data lookup.
- R7: Attribute decode works as follows.
  - A code below 12 grants read. Bit 0 grants execute and bit 1 grants write. Bits 3:2 give the cache mode: 0 means bypass (`res_cache` 0), 1 means write-back (`res_cache` 1), 2 means write-through (`res_cache` 2).
  - Code 13 grants read and write with isolate mode (`res_cache` 3).
  - Codes 12, 14 and 15 grant nothing.
  - `res_rights` bit 2 is read, bit 1 is write, bit 0 is execute.
- R8: A data lookup (`lk_is_inst`=0) removes execute, and an instruction lookup removes read and write. The access type `lk_acc` is 0 for read, 1 for write and 2 for fetch, and needs read, write or execute respectively. When that right is missing, the cause is 4 for an instruction lookup, 9 for a data write and 8 for any other data lookup.
- R9: On success (cause 0), `res_paddr` is the entry's physical page ORed with the lookup address bits below that way's page offset. `res_rights` carries the stripped rights.
- R10: Reset sets the ring register to 0x04030201 and clears the identifier of every entry, so every lookup misses until entries are written.
- R11: On any fault, `res_paddr`, `res_rights`, `res_cache` and `res_ring` are zero.
- R12: A write with `wr_en` stores tag, physical page, identifier and attribute into way `wr_way` at the index taken from `wr_vaddr`, replacing what was there. `ring_we` loads `ring_wdata` into the ring register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 2 | Target way of the write |
| wr_vaddr | input | 32 | Virtual address of the written page (gives tag and index) |
| wr_ppn | input | 32 | Physical page base of the written entry |
| wr_asid | input | 8 | Address-space identifier of the written entry |
| wr_attr | input | 4 | Attribute code of the written entry |
| ring_we | input | 1 | Ring register write strobe |
| ring_wdata | input | 32 | New ring register value, byte n for ring n |
| lk_valid | input | 1 | Lookup request |
| lk_is_inst | input | 1 | 1 for an instruction lookup, 0 for data |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| lk_priv | input | 2 | Requester's ring |
| lk_vaddr | input | 32 | Virtual address to translate |
| res_valid | output | 1 | Result valid |
| res_cause | output | 4 | 0 on success, otherwise the fault cause |
| res_paddr | output | 32 | Translated physical address |
| res_rights | output | 3 | Granted rights: read, write, execute |
| res_cache | output | 2 | Cache mode of the hit entry |
| res_ring | output | 2 | Ring of the hit entry |

## Verification
The bench loads entries into every way with different page sizes, rings and attribute codes. It then probes the offset boundaries of each way. A design that used the wrong offset width for a way would return a corrupted physical address or miss a page that should hit.

Two ways are loaded to hit the same address. A design that silently took the first hit would return a translation instead of the multi-hit cause. The bench also rewrites the ring register, first so that an identifier vanishes and then so that it appears in several bytes. A design that searched from the top byte, or that ignored the register, would report the wrong ring or the wrong privilege outcome.

Isolate, no-access and execute-only attributes are used with both lookup sides. This catches a design that forgets to strip rights by side or that mixes up the store and load causes. A second reset checks that stale entries do not survive.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [3:0] {
    CAUSE_OK          = 4'd0,
    CAUSE_I_MISS      = 4'd1,
    CAUSE_I_MULTI     = 4'd2,
    CAUSE_I_PRIV      = 4'd3,
    CAUSE_FETCH_DENY  = 4'd4,
    CAUSE_D_MISS      = 4'd5,
    CAUSE_D_MULTI     = 4'd6,
    CAUSE_D_PRIV      = 4'd7,
    CAUSE_LOAD_DENY   = 4'd8,
    CAUSE_STORE_DENY  = 4'd9
  } cause_t;

  typedef enum logic [1:0] {
    CM_BYPASS  = 2'd0,
    CM_WBACK   = 2'd1,
    CM_WTHRU   = 2'd2,
    CM_ISOLATE = 2'd3
  } cache_mode_t;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int RIGHT_R = 2;
  localparam int RIGHT_W = 1;
  localparam int RIGHT_X = 0;

  localparam int NUM_RINGS = 4;

endpackage

// File: rtl/tlb_ring_match.sv
module tlb_ring_match #(
  parameter int ASID_W = 8
) (
  input  logic [4*ASID_W-1:0] ring_ids,
  input  logic [ASID_W-1:0]   asid,
  output logic                found,
  output logic [1:0]          ring
);
  always_comb begin
    found = 1'b0;
    ring  = 2'd0;
    // walk from the top so the lowest matching byte wins
    for (int i = tlb_pkg::NUM_RINGS - 1; i >= 0; i--) begin
      if (ring_ids[i*ASID_W +: ASID_W] == asid) begin
        found = 1'b1;
        ring  = 2'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_attr_decode.sv
module tlb_attr_decode
  import tlb_pkg::*;
(
  input  logic [3:0]  attr,
  output logic [2:0]  rights,
  output cache_mode_t cache
);
  always_comb begin
    rights = 3'b000;
    cache  = CM_BYPASS;
    if (attr < 4'd12) begin
      rights[RIGHT_R] = 1'b1;
      rights[RIGHT_X] = attr[0];
      rights[RIGHT_W] = attr[1];
      case (attr[3:2])
        2'b01:   cache = CM_WBACK;
        2'b10:   cache = CM_WTHRU;
        default: cache = CM_BYPASS;
      endcase
    end else if (attr == 4'd13) begin
      rights[RIGHT_R] = 1'b1;
      rights[RIGHT_W] = 1'b1;
      cache           = CM_ISOLATE;
    end
  end

  always_comb begin
    AST_WRITE_IMPLIES_READ: assert (!rights[RIGHT_W] || rights[RIGHT_R]); // R7
  end
endmodule

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int ADDR_W    = 32,
  parameter int IDX_BITS  = 2,
  parameter int PAGE_BITS = 12,
  parameter int ASID_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_vaddr,
  input  logic [ADDR_W-1:0]   wr_ppn,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic [3:0]          wr_attr,
  input  logic [4*ASID_W-1:0] ring_ids,
  input  logic [ADDR_W-1:0]   lk_vaddr,
  output logic                hit,
  output logic [1:0]          ring,
  output logic [ADDR_W-1:0]   paddr,
  output logic [3:0]          attr
);
  localparam int ENTRIES = 1 << IDX_BITS;
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << PAGE_BITS) - 64'd1);

  logic [ADDR_W-1:0] tag_mem  [ENTRIES];
  logic [ADDR_W-1:0] ppn_mem  [ENTRIES];
  logic [3:0]        attr_mem [ENTRIES];
  logic [ASID_W-1:0] asid_q   [ENTRIES];

  logic [IDX_BITS-1:0] wr_idx;
  logic [IDX_BITS-1:0] lk_idx;

  assign wr_idx = wr_vaddr[PAGE_BITS +: IDX_BITS];
  assign lk_idx = lk_vaddr[PAGE_BITS +: IDX_BITS];

  // payload fields carry no reset so they map onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_vaddr & ~OFF_MASK;
      ppn_mem[wr_idx]  <= wr_ppn & ~OFF_MASK;
      attr_mem[wr_idx] <= wr_attr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) asid_q[e] <= '0;
    end else if (wr_en) begin
      asid_q[wr_idx] <= wr_asid;
    end
  end

  logic [ASID_W-1:0] sel_asid;
  logic              ring_found;

  assign sel_asid = asid_q[lk_idx];

  tlb_ring_match #(.ASID_W(ASID_W)) u_ring (
    .ring_ids (ring_ids),
    .asid     (sel_asid),
    .found    (ring_found),
    .ring     (ring)
  );

  assign hit   = (tag_mem[lk_idx] == (lk_vaddr & ~OFF_MASK)) &&
                 (sel_asid != '0) && ring_found;
  assign paddr = ppn_mem[lk_idx] | (lk_vaddr & OFF_MASK);
  assign attr  = attr_mem[lk_idx];
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_WAYS  = 4,
  parameter int IDX_BITS  = 2,
  parameter int PAGE_MIN  = 12,
  parameter int PAGE_STEP = 2,
  parameter int ASID_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(NUM_WAYS)-1:0] wr_way,
  input  logic [ADDR_W-1:0]          wr_vaddr,
  input  logic [ADDR_W-1:0]          wr_ppn,
  input  logic [ASID_W-1:0]          wr_asid,
  input  logic [3:0]                 wr_attr,
  input  logic                       ring_we,
  input  logic [4*ASID_W-1:0]        ring_wdata,
  input  logic                       lk_valid,
  input  logic                       lk_is_inst,
  input  logic [1:0]                 lk_acc,
  input  logic [1:0]                 lk_priv,
  input  logic [ADDR_W-1:0]          lk_vaddr,
  output logic                       res_valid,
  output logic [3:0]                 res_cause,
  output logic [ADDR_W-1:0]          res_paddr,
  output logic [2:0]                 res_rights,
  output logic [1:0]                 res_cache,
  output logic [1:0]                 res_ring
);
  localparam int WAY_W  = $clog2(NUM_WAYS);
  localparam int RING_W = 4 * ASID_W;

  function automatic logic [RING_W-1:0] ring_reset_value();
    logic [RING_W-1:0] v;
    for (int i = 0; i < NUM_RINGS; i++) v[i*ASID_W +: ASID_W] = ASID_W'(i + 1);
    return v;
  endfunction

  localparam logic [RING_W-1:0] RING_RST = ring_reset_value();

  logic [RING_W-1:0] ring_q;

  always_ff @(posedge clk) begin
    if (rst)          ring_q <= RING_RST;
    else if (ring_we) ring_q <= ring_wdata;
  end

  logic [NUM_WAYS-1:0] hit_vec;
  logic [1:0]          way_ring  [NUM_WAYS];
  logic [ADDR_W-1:0]   way_paddr [NUM_WAYS];
  logic [3:0]          way_attr  [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    localparam int PB = PAGE_MIN + w * PAGE_STEP;
    logic way_we;
    assign way_we = wr_en && (wr_way == WAY_W'(w));

    tlb_way #(
      .ADDR_W    (ADDR_W),
      .IDX_BITS  (IDX_BITS),
      .PAGE_BITS (PB),
      .ASID_W    (ASID_W)
    ) u_way (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (way_we),
      .wr_vaddr (wr_vaddr),
      .wr_ppn   (wr_ppn),
      .wr_asid  (wr_asid),
      .wr_attr  (wr_attr),
      .ring_ids (ring_q),
      .lk_vaddr (lk_vaddr),
      .hit      (hit_vec[w]),
      .ring     (way_ring[w]),
      .paddr    (way_paddr[w]),
      .attr     (way_attr[w])
    );
  end

  // pick the lowest hitting way and count hits
  logic [WAY_W:0]     hit_cnt;
  logic [1:0]         sel_ring;
  logic [ADDR_W-1:0]  sel_paddr;
  logic [3:0]         sel_attr;

  always_comb begin
    hit_cnt   = '0;
    sel_ring  = '0;
    sel_paddr = '0;
    sel_attr  = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        hit_cnt   = hit_cnt + 1'b1;
        sel_ring  = way_ring[w];
        sel_paddr = way_paddr[w];
        sel_attr  = way_attr[w];
      end
    end
  end

  logic [2:0]  raw_rights;
  cache_mode_t raw_cache;

  tlb_attr_decode u_attr (
    .attr   (sel_attr),
    .rights (raw_rights),
    .cache  (raw_cache)
  );

  logic [2:0] side_rights;
  logic       granted;
  cause_t     nxt_cause;

  always_comb begin
    side_rights = lk_is_inst ? (raw_rights & 3'b001) : (raw_rights & 3'b110);
    case (lk_acc)
      ACC_READ:  granted = side_rights[RIGHT_R];
      ACC_WRITE: granted = side_rights[RIGHT_W];
      ACC_FETCH: granted = side_rights[RIGHT_X];
      default:   granted = 1'b0;
    endcase

    if (hit_cnt == '0)
      nxt_cause = lk_is_inst ? CAUSE_I_MISS : CAUSE_D_MISS;
    else if (hit_cnt > 1)
      nxt_cause = lk_is_inst ? CAUSE_I_MULTI : CAUSE_D_MULTI;
    else if (sel_ring < lk_priv)
      nxt_cause = lk_is_inst ? CAUSE_I_PRIV : CAUSE_D_PRIV;
    else if (!granted)
      nxt_cause = lk_is_inst ? CAUSE_FETCH_DENY :
                  (lk_acc == ACC_WRITE) ? CAUSE_STORE_DENY : CAUSE_LOAD_DENY;
    else
      nxt_cause = CAUSE_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_cause  <= CAUSE_OK;
      res_paddr  <= '0;
      res_rights <= '0;
      res_cache  <= '0;
      res_ring   <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_cause <= nxt_cause;
        if (nxt_cause == CAUSE_OK) begin
          res_paddr  <= sel_paddr;
          res_rights <= side_rights;
          res_cache  <= raw_cache;
          res_ring   <= sel_ring;
        end else begin
          res_paddr  <= '0;
          res_rights <= '0;
          res_cache  <= '0;
          res_ring   <= '0;
        end
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid); // R1

  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid); // R1

  AST_MULTI_HIT_FAULT: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && $countones(hit_vec) > 1) |=>
      (res_cause == CAUSE_I_MULTI || res_cause == CAUSE_D_MULTI)); // R4

  AST_RING_NOT_BELOW_PRIV: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !$isunknown(lk_priv)) ##1 (res_valid && res_cause == CAUSE_OK) |->
      res_ring >= $past(lk_priv)); // R6

  AST_FAULT_CLEARS_DATA: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_cause != CAUSE_OK) |->
      (res_paddr == '0 && res_rights == '0 && res_cache == '0 && res_ring == '0)); // R11

  AST_MISS_WHEN_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && hit_vec == '0) |=>
      (res_cause == CAUSE_I_MISS || res_cause == CAUSE_D_MISS)); // R5
endmodule

// File: tb/test_tlb_lookup.sv
module test_tlb_lookup;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_way;
  logic [31:0] wr_vaddr;
  logic [31:0] wr_ppn;
  logic [7:0]  wr_asid;
  logic [3:0]  wr_attr;
  logic        ring_we;
  logic [31:0] ring_wdata;
  logic        lk_valid;
  logic        lk_is_inst;
  logic [1:0]  lk_acc;
  logic [1:0]  lk_priv;
  logic [31:0] lk_vaddr;
  logic        res_valid;
  logic [3:0]  res_cause;
  logic [31:0] res_paddr;
  logic [2:0]  res_rights;
  logic [1:0]  res_cache;
  logic [1:0]  res_ring;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tlb_lookup i_tlb_lookup (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_way(wr_way), .wr_vaddr(wr_vaddr), .wr_ppn(wr_ppn),
    .wr_asid(wr_asid), .wr_attr(wr_attr),
    .ring_we(ring_we), .ring_wdata(ring_wdata),
    .lk_valid(lk_valid), .lk_is_inst(lk_is_inst), .lk_acc(lk_acc),
    .lk_priv(lk_priv), .lk_vaddr(lk_vaddr),
    .res_valid(res_valid), .res_cause(res_cause), .res_paddr(res_paddr),
    .res_rights(res_rights), .res_cache(res_cache), .res_ring(res_ring)
  );

  typedef struct packed {
    logic        is_inst;
    logic [1:0]  acc;
    logic [1:0]  priv;
    logic [31:0] va;
    logic [3:0]  cause;
    logic [31:0] pa;
    logic [2:0]  rights;
    logic [1:0]  cache;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 2'd0, 32'h0000_1234, 4'd0, 32'h8000_0234, 3'b110, 2'd0}, // R9 R8
    '{1'b0, 2'd1, 2'd0, 32'h0000_1FFC, 4'd0, 32'h8000_0FFC, 3'b110, 2'd0}, // R9 offset edge
    '{1'b1, 2'd2, 2'd0, 32'h0000_1010, 4'd0, 32'h8000_0010, 3'b001, 2'd0}, // R8 inst side
    '{1'b0, 2'd0, 2'd1, 32'h0000_1000, 4'd7, 32'h0,         3'b000, 2'd0}, // R6
    '{1'b0, 2'd0, 2'd1, 32'h1000_4ABC, 4'd0, 32'h2000_0ABC, 3'b100, 2'd1}, // R7 write-back
    '{1'b0, 2'd1, 2'd1, 32'h1000_4ABC, 4'd9, 32'h0,         3'b000, 2'd0}, // R8 store deny
    '{1'b1, 2'd2, 2'd0, 32'h1000_4000, 4'd4, 32'h0,         3'b000, 2'd0}, // R8 fetch deny
    '{1'b0, 2'd1, 2'd3, 32'h2001_2345, 4'd0, 32'h3000_2345, 3'b110, 2'd3}, // R7 isolate
    '{1'b1, 2'd2, 2'd3, 32'h2001_0000, 4'd4, 32'h0,         3'b000, 2'd0}, // R7 isolate no exec
    '{1'b1, 2'd2, 2'd2, 32'h3004_0100, 4'd0, 32'h4000_0100, 3'b001, 2'd2}, // R7 write-through
    '{1'b0, 2'd0, 2'd2, 32'h3007_FFFF, 4'd0, 32'h4003_FFFF, 3'b100, 2'd2}, // R2 R9 largest page
    '{1'b0, 2'd0, 2'd0, 32'h5000_0000, 4'd8, 32'h0,         3'b000, 2'd0}, // R7 code 14
    '{1'b0, 2'd0, 2'd0, 32'h6000_2000, 4'd6, 32'h0,         3'b000, 2'd0}, // R4 data
    '{1'b1, 2'd2, 2'd0, 32'h6000_2000, 4'd2, 32'h0,         3'b000, 2'd0}, // R4 inst
    '{1'b0, 2'd0, 2'd0, 32'h7000_0000, 4'd5, 32'h0,         3'b000, 2'd0}, // R3 unmatched id
    '{1'b1, 2'd2, 2'd0, 32'h7000_0000, 4'd1, 32'h0,         3'b000, 2'd0}, // R5 inst miss
    '{1'b0, 2'd0, 2'd0, 32'h0000_3000, 4'd5, 32'h0,         3'b000, 2'd0}  // R5 R2 zero id
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_entry(logic [1:0] way, logic [31:0] va, logic [31:0] pp,
                             logic [7:0] id, logic [3:0] at);
    @(negedge clk);
    wr_en = 1'b1; wr_way = way; wr_vaddr = va; wr_ppn = pp; wr_asid = id; wr_attr = at;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_ring(logic [31:0] v);
    @(negedge clk);
    ring_we = 1'b1; ring_wdata = v;
    @(negedge clk);
    ring_we = 1'b0;
  endtask

  task automatic lookup(logic inst, logic [1:0] acc, logic [1:0] priv, logic [31:0] va);
    @(negedge clk);
    lk_valid = 1'b1; lk_is_inst = inst; lk_acc = acc; lk_priv = priv; lk_vaddr = va;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_way = '0; wr_vaddr = '0; wr_ppn = '0; wr_asid = '0;
    wr_attr = '0; ring_we = 1'b0; ring_wdata = '0; lk_valid = 1'b0; lk_is_inst = 1'b0;
    lk_acc = '0; lk_priv = '0; lk_vaddr = '0;
    do_reset();

    // R10 reset state: no result, every lookup misses
    check("R1 res_valid after reset", 64'(res_valid), 64'd0);
    lookup(1'b0, 2'd0, 2'd0, 32'h0000_1234);
    check("R1 res_valid after request", 64'(res_valid), 64'd1);
    check("R10 empty table misses", 64'(res_cause), 64'd5);

    // R12 load entries
    write_entry(2'd0, 32'h0000_1000, 32'h8000_0000, 8'd1, 4'd3);
    write_entry(2'd1, 32'h1000_4000, 32'h2000_0000, 8'd2, 4'd4);
    write_entry(2'd2, 32'h2001_0000, 32'h3000_0000, 8'd4, 4'd13);
    write_entry(2'd3, 32'h3004_0000, 32'h4000_0000, 8'd3, 4'd9);
    write_entry(2'd0, 32'h5000_0000, 32'h5500_0000, 8'd1, 4'd14);
    write_entry(2'd0, 32'h6000_2000, 32'h6600_0000, 8'd1, 4'd2);
    write_entry(2'd1, 32'h6000_0000, 32'h6700_0000, 8'd1, 4'd2);
    write_entry(2'd2, 32'h7000_0000, 32'h7700_0000, 8'h55, 4'd3);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].is_inst, VECS[i].acc, VECS[i].priv, VECS[i].va);
      check($sformatf("R2/R4/R5/R6/R7/R8/R9/R11 row %0d", i),
            {23'd0, res_cause, res_paddr, res_rights, res_cache},
            {23'd0, VECS[i].cause, VECS[i].pa, VECS[i].rights, VECS[i].cache});
    end

    // R1 idle cycle gives no result
    @(negedge clk);
    check("R1 idle res_valid", 64'(res_valid), 64'd0);

    // R3 default ring register: id 4 is ring 3, id 3 is ring 2
    lookup(1'b0, 2'd0, 2'd3, 32'h2001_0000);
    check("R3 ring of id 4", 64'(res_ring), 64'd3);
    lookup(1'b0, 2'd0, 2'd0, 32'h3004_0000);
    check("R3 ring of id 3", 64'(res_ring), 64'd2);

    // R3 id 2 removed from ring register: entry treated as absent
    write_ring(32'h0A09_0801);
    lookup(1'b0, 2'd0, 2'd0, 32'h1000_4ABC);
    check("R3 vanished id misses", 64'(res_cause), 64'd5);
    lookup(1'b0, 2'd0, 2'd0, 32'h0000_1234);
    check("R3 kept id hits", 64'(res_cause), 64'd0);

    // R3 duplicated id: lowest byte wins
    write_ring(32'h0202_0201);
    lookup(1'b0, 2'd0, 2'd1, 32'h1000_4ABC);
    check("R3 lowest byte cause", 64'(res_cause), 64'd0);
    check("R3 lowest byte ring", 64'(res_ring), 64'd1);
    lookup(1'b0, 2'd0, 2'd2, 32'h1000_4ABC);
    check("R6 ring below priv", 64'(res_cause), 64'd7);

    // R12 overwrite an entry
    write_entry(2'd0, 32'h0000_1000, 32'h9000_0000, 8'd1, 4'd3);
    lookup(1'b0, 2'd0, 2'd0, 32'h0000_1234);
    check("R12 overwritten page", 64'(res_paddr), 64'h9000_0234);

    // R10 second reset clears entries and restores ring register
    do_reset();
    lookup(1'b0, 2'd0, 2'd0, 32'h0000_1234);
    check("R10 entries cleared", 64'(res_cause), 64'd5);
    write_entry(2'd2, 32'h2001_0000, 32'h3000_0000, 8'd4, 4'd13);
    lookup(1'b0, 2'd0, 2'd3, 32'h2001_0010);
    check("R10 ring default cause", 64'(res_cause), 64'd0);
    check("R10 ring default ring", 64'(res_ring), 64'd3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule